// File: doc/BRIEF.md
# DRAM Bank Command Sequencer

This block sits on the controller side of one DRAM bank. It takes one read or write request at a time, each carrying a row and a column address. It turns the request into the shortest legal command sequence on a shared command and address bus. It remembers which row is open. A request to the open row goes straight to the column command. A request to a closed bank starts with an activate. A request to another row first closes the open row, then activates the new one, then issues the column command.

Three countdown delays set the spacing between commands, and each is a runtime input: activate to column access, column access to data, and precharge to the next activate. The row half and the column half of the address go out on the same address field, each during its own command. A data-valid strobe marks the eight beats of the burst. The requester sees a valid/ready handshake and can send its next request once that burst has finished.

Top module: `dram_bank_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, `cmd` is NOP (code 0), `cmd_addr` is zero, `req_ready` is 1, `data_valid` is 0 and `bank_open` is 0.
- R2: A request accepted while the bank is closed issues ACT (code 1) in the cycle after acceptance, followed by the column command.
- R3: A request to the row that is already open issues no PRE and no ACT. The column command appears in the cycle after acceptance.
- R4: A request to a row other than the open one issues PRE (code 4) in the cycle after acceptance, then ACT, then the column command. ACT is never issued while a row is open.
- R5: The column command follows ACT by exactly `t_rcd` cycles. A value of 0 is treated as 1.
- R6: `data_valid` rises exactly `t_cl` cycles after the column command (0 treated as 1) and stays high for exactly 8 consecutive cycles.
- R7: ACT follows PRE by exactly `t_rp` cycles. A value of 0 is treated as 1.
- R8: `cmd_addr` carries the zero-extended row during ACT and the zero-extended column during RD or WR. It is zero on every NOP and PRE cycle.
- R9: `req_ready` goes low in the cycle after acceptance and stays low until the cycle after the last `data_valid` beat, when it returns high.
- R10: Every cycle without a legal command carries NOP, so a row hit shows exactly 1 non-NOP command, a closed-bank access 2 and a row miss 3.
- R11: After an access, `bank_open` is 1 and `open_row` holds the row of that access.
- R12: The column command is WR (code 3) when `req_write` was 1 at acceptance, and RD (code 2) otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row address of the request |
| req_col | input | COL_W | Column address of the request |
| t_rcd | input | TW | Activate-to-column delay in cycles |
| t_cl | input | TW | Column-to-data delay in cycles |
| t_rp | input | TW | Precharge-to-activate delay in cycles |
| cmd | output | 3 | Command code: 0 NOP, 1 ACT, 2 RD, 3 WR, 4 PRE |
| cmd_addr | output | max(ROW_W,COL_W) | Shared row/column address field |
| data_valid | output | 1 | High during the 8 burst beats |
| bank_open | output | 1 | A row is currently open |
| open_row | output | ROW_W | Row currently open |

## Verification
Every command is registered, so the first command of a sequence appears one cycle after the accepting edge. Each later command lands exactly `t_rp`, `t_rcd` or `t_cl` cycles after the one before it. The bench samples at the falling edge and stamps every command and data beat with the count of rising edges so far. For each request it predicts the exact cycle of PRE, ACT, the column command, the first and last data beat and the return of ready, using the acceptance cycle and the clamped delays. It compares those stamps against the prediction instead of waiting for an event. An independent open-row model decides whether a hit, a closed-bank access or a miss is expected.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } dram_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_ACT,
    ST_WAIT_COL,
    ST_WAIT_DATA,
    ST_BURST
  } seq_state_e;
endpackage

// File: rtl/dbs_delay_timer.sv
module dbs_delay_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val - TW'(1);
    else if (cnt_q != '0)
      cnt_q <= cnt_q - TW'(1);
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/dbs_burst_gen.sv
module dbs_burst_gen #(
  parameter int BURST_LEN = 8,
  localparam int BW = (BURST_LEN > 2) ? $clog2(BURST_LEN) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic active,
  output logic last
);
  logic [BW-1:0] beat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      beat_q <= '0;
    end else if (start) begin
      active <= 1'b1;
      beat_q <= BW'(BURST_LEN - 1);
    end else if (active) begin
      if (beat_q == '0)
        active <= 1'b0;
      else
        beat_q <= beat_q - BW'(1);
    end
  end

  assign last = active && (beat_q == '0);
endmodule

// File: rtl/dbs_row_tracker.sv
module dbs_row_tracker #(
  parameter int ROW_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_en,
  input  logic             close_en,
  input  logic [ROW_W-1:0] open_row_in,
  input  logic [ROW_W-1:0] cmp_row,
  output logic             is_open,
  output logic [ROW_W-1:0] row_q,
  output logic             hit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      is_open <= 1'b0;
      row_q   <= '0;
    end else if (open_en) begin
      is_open <= 1'b1;
      row_q   <= open_row_in;
    end else if (close_en) begin
      is_open <= 1'b0;
    end
  end

  assign hit = is_open && (row_q == cmp_row);
endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq #(
  parameter int ROW_W     = 16,
  parameter int COL_W     = 10,
  parameter int TW        = 4,
  parameter int BURST_LEN = 8,
  localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [TW-1:0]     t_rcd,
  input  logic [TW-1:0]     t_cl,
  input  logic [TW-1:0]     t_rp,
  output logic [2:0]        cmd,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              data_valid,
  output logic              bank_open,
  output logic [ROW_W-1:0]  open_row
);
  import dbs_pkg::*;

  seq_state_e state_q, state_d;
  dram_cmd_e  cmd_q, cmd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;

  logic [ROW_W-1:0] hold_row;
  logic [COL_W-1:0] hold_col;
  logic             hold_write;

  logic [TW-1:0] rcd_eff, cl_eff, rp_eff, tmr_val;
  logic          tmr_load, tmr_expired;
  logic          burst_start, burst_last;
  logic          trk_open, trk_close, trk_hit;
  logic [ROW_W-1:0] act_row;
  logic          accept;

  assign rcd_eff = (t_rcd == '0) ? TW'(1) : t_rcd;
  assign cl_eff  = (t_cl  == '0) ? TW'(1) : t_cl;
  assign rp_eff  = (t_rp  == '0) ? TW'(1) : t_rp;

  assign accept  = (state_q == ST_IDLE) && req_valid;
  assign act_row = (state_q == ST_IDLE) ? req_row : hold_row;

  dbs_delay_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  dbs_burst_gen #(.BURST_LEN(BURST_LEN)) u_burst (
    .clk    (clk),
    .rst    (rst),
    .start  (burst_start),
    .active (data_valid),
    .last   (burst_last)
  );

  dbs_row_tracker #(.ROW_W(ROW_W)) u_rows (
    .clk         (clk),
    .rst         (rst),
    .open_en     (trk_open),
    .close_en    (trk_close),
    .open_row_in (act_row),
    .cmp_row     (req_row),
    .is_open     (bank_open),
    .row_q       (open_row),
    .hit         (trk_hit)
  );

  always_comb begin
    state_d     = state_q;
    cmd_d       = CMD_NOP;
    addr_d      = '0;
    tmr_load    = 1'b0;
    tmr_val     = rcd_eff;
    burst_start = 1'b0;
    trk_open    = 1'b0;
    trk_close   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          tmr_load = 1'b1;
          if (trk_hit) begin
            cmd_d   = req_write ? CMD_WR : CMD_RD;
            addr_d  = ADDR_W'(req_col);
            tmr_val = cl_eff;
            state_d = ST_WAIT_DATA;
          end else if (bank_open) begin
            cmd_d     = CMD_PRE;
            trk_close = 1'b1;
            tmr_val   = rp_eff;
            state_d   = ST_WAIT_ACT;
          end else begin
            cmd_d    = CMD_ACT;
            addr_d   = ADDR_W'(req_row);
            trk_open = 1'b1;
            tmr_val  = rcd_eff;
            state_d  = ST_WAIT_COL;
          end
        end
      end
      ST_WAIT_ACT: begin
        if (tmr_expired) begin
          cmd_d    = CMD_ACT;
          addr_d   = ADDR_W'(hold_row);
          trk_open = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = rcd_eff;
          state_d  = ST_WAIT_COL;
        end
      end
      ST_WAIT_COL: begin
        if (tmr_expired) begin
          cmd_d    = hold_write ? CMD_WR : CMD_RD;
          addr_d   = ADDR_W'(hold_col);
          tmr_load = 1'b1;
          tmr_val  = cl_eff;
          state_d  = ST_WAIT_DATA;
        end
      end
      ST_WAIT_DATA: begin
        if (tmr_expired) begin
          burst_start = 1'b1;
          state_d     = ST_BURST;
        end
      end
      ST_BURST: begin
        if (burst_last) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cmd_q      <= CMD_NOP;
      addr_q     <= '0;
      hold_row   <= '0;
      hold_col   <= '0;
      hold_write <= 1'b0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      addr_q  <= addr_d;
      if (accept) begin
        hold_row   <= req_row;
        hold_col   <= req_col;
        hold_write <= req_write;
      end
    end
  end

  assign cmd       = cmd_q;
  assign cmd_addr  = addr_q;
  assign req_ready = (state_q == ST_IDLE);
endmodule

// File: rtl/dbs_checker.sv
module dbs_checker #(
  parameter int TW        = 4,
  parameter int BURST_LEN = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    cmd,
  input logic          bank_open,
  input logic          data_valid,
  input logic          req_ready,
  input logic [TW-1:0] t_rcd,
  input logic [TW-1:0] t_cl,
  input logic [TW-1:0] t_rp
);
  import dbs_pkg::*;

  function automatic logic [7:0] eff(input logic [TW-1:0] v);
    return (v == '0) ? 8'd1 : 8'(v);
  endfunction

  logic [7:0] since_act, since_pre, since_col, run_len;
  logic [2:0] last_cmd;
  logic       is_col;

  assign is_col = (cmd == CMD_RD) || (cmd == CMD_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      since_act <= '0;
      since_pre <= '0;
      since_col <= '0;
      run_len   <= '0;
      last_cmd  <= CMD_NOP;
    end else begin
      since_act <= (cmd == CMD_ACT) ? 8'd1 : (since_act == 8'hFF ? since_act : since_act + 8'd1);
      since_pre <= (cmd == CMD_PRE) ? 8'd1 : (since_pre == 8'hFF ? since_pre : since_pre + 8'd1);
      since_col <= is_col ? 8'd1 : (since_col == 8'hFF ? since_col : since_col + 8'd1);
      run_len   <= data_valid ? run_len + 8'd1 : 8'd0;
      if (cmd != CMD_NOP) last_cmd <= cmd;
    end
  end

  AST_COL_NEEDS_OPEN: assert property (@(posedge clk) disable iff (rst)
    is_col |-> bank_open); // R2

  AST_ACT_ONLY_CLOSED: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_ACT) |-> !$past(bank_open)); // R4

  AST_RCD_SPACING: assert property (@(posedge clk) disable iff (rst)
    (is_col && last_cmd == CMD_ACT) |-> (since_act == eff(t_rcd))); // R5

  AST_CL_SPACING: assert property (@(posedge clk) disable iff (rst)
    $rose(data_valid) |-> (since_col == eff(t_cl))); // R6

  AST_BURST_LEN_MAX: assert property (@(posedge clk) disable iff (rst)
    data_valid |-> (run_len < 8'(BURST_LEN))); // R6

  AST_BURST_LEN_EXACT: assert property (@(posedge clk) disable iff (rst)
    $fell(data_valid) |-> (run_len == 8'(BURST_LEN))); // R6

  AST_RP_SPACING: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_ACT && last_cmd == CMD_PRE) |-> (since_pre == eff(t_rp))); // R7

  AST_BUSY_DURING_BURST: assert property (@(posedge clk) disable iff (rst)
    data_valid |-> !req_ready); // R9
endmodule

bind dram_bank_seq dbs_checker #(.TW(TW), .BURST_LEN(BURST_LEN)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd        (cmd),
  .bank_open  (bank_open),
  .data_valid (data_valid),
  .req_ready  (req_ready),
  .t_rcd      (t_rcd),
  .t_cl       (t_cl),
  .t_rp       (t_rp)
);

// File: tb/dram_bank_seq_test.sv
`timescale 1ns/1ps
module dram_bank_seq_test;
  localparam int ROW_W = 16;
  localparam int COL_W = 10;
  localparam int TW    = 4;
  localparam int ADDR_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [TW-1:0] t_rcd = 4'd3, t_cl = 4'd4, t_rp = 4'd5;
  logic req_ready, data_valid, bank_open;
  logic [2:0] cmd;
  logic [ADDR_W-1:0] cmd_addr;
  logic [ROW_W-1:0] open_row;

  int checks = 0, errors = 0;
  int cyc = 0;
  bit finished = 0;

  int act_cyc, pre_cyc, col_cyc, dv_first, dv_last, dv_cnt, ncmd, nop_bad;
  int act_addr, col_addr, col_code;
  bit mdl_open = 0;
  int mdl_row = 0;

  dram_bank_seq uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_row(req_row), .req_col(req_col),
    .t_rcd(t_rcd), .t_cl(t_cl), .t_rp(t_rp), .cmd(cmd), .cmd_addr(cmd_addr),
    .data_valid(data_valid), .bank_open(bank_open), .open_row(open_row)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  always @(negedge clk) begin
    if (cmd != 3'd0) ncmd++;
    if ((cmd == 3'd0 || cmd == 3'd4) && cmd_addr != '0) nop_bad++;
    case (cmd)
      3'd1: begin act_cyc = cyc; act_addr = int'(cmd_addr); end
      3'd4: pre_cyc = cyc;
      3'd2, 3'd3: begin col_cyc = cyc; col_code = int'(cmd); col_addr = int'(cmd_addr); end
      default: ;
    endcase
    if (data_valid) begin
      if (dv_cnt == 0) dv_first = cyc;
      dv_cnt++;
      dv_last = cyc;
    end
  end

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic int clampv(input logic [TW-1:0] v);
    return (v == '0) ? 1 : int'(v);
  endfunction

  task automatic run_req(input bit wr, input int row, input int col);
    int acc, rdy_cyc, rcd, cl, rp, colc, exp_n;
    bit got_ready;
    @(negedge clk);
    act_cyc = -1; pre_cyc = -1; col_cyc = -1; dv_cnt = 0; ncmd = 0; nop_bad = 0;
    dv_first = -1; dv_last = -1;
    req_valid = 1'b1; req_write = wr;
    req_row = ROW_W'(row); req_col = COL_W'(col);
    acc = cyc + 1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9", "ready low after accept", int'(req_ready), 0);
    got_ready = 0; rdy_cyc = -1;
    for (int i = 0; i < 200 && !got_ready; i++) begin
      @(negedge clk);
      if (req_ready) begin got_ready = 1; rdy_cyc = cyc; end
    end
    check("R9", "ready returned", int'(got_ready), 1);
    rcd = clampv(t_rcd); cl = clampv(t_cl); rp = clampv(t_rp);
    if (mdl_open && mdl_row == row) begin
      colc = acc; exp_n = 1;
      check("R3", "no ACT on hit", act_cyc, -1);
      check("R3", "no PRE on hit", pre_cyc, -1);
    end else if (mdl_open) begin
      exp_n = 3;
      check("R4", "PRE cycle", pre_cyc, acc);
      check("R7", "ACT after PRE", act_cyc, acc + rp);
      colc = acc + rp + rcd;
      check("R8", "row on ACT", act_addr, row);
    end else begin
      exp_n = 2;
      check("R2", "ACT cycle", act_cyc, acc);
      check("R2", "no PRE when closed", pre_cyc, -1);
      colc = acc + rcd;
      check("R8", "row on ACT", act_addr, row);
    end
    check("R5", "column cycle", col_cyc, colc);
    check("R12", "column code", col_code, wr ? 3 : 2);
    check("R8", "column on RD/WR", col_addr, col);
    check("R8", "zero address on NOP/PRE", nop_bad, 0);
    check("R6", "first data beat", dv_first, colc + cl);
    check("R6", "beat count", dv_cnt, 8);
    check("R6", "last data beat", dv_last, colc + cl + 7);
    check("R9", "ready return cycle", rdy_cyc, colc + cl + 8);
    check("R10", "non-NOP commands", ncmd, exp_n);
    check("R11", "bank open", int'(bank_open), 1);
    check("R11", "open row", int'(open_row), row);
    mdl_open = 1; mdl_row = row;
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "cmd in reset", int'(cmd), 0);
    check("R1", "ready in reset", int'(req_ready), 1);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "cmd after reset", int'(cmd), 0);
    check("R1", "addr after reset", int'(cmd_addr), 0);
    check("R1", "ready after reset", int'(req_ready), 1);
    check("R1", "data_valid after reset", int'(data_valid), 0);
    check("R1", "bank closed after reset", int'(bank_open), 0);
  endtask

  task automatic test_closed_read();
    t_rcd = 4'd3; t_cl = 4'd4; t_rp = 4'd5;
    run_req(1'b0, 16'h1234, 10'h2A5);
  endtask

  task automatic test_hit_write();
    run_req(1'b1, 16'h1234, 10'h011);
  endtask

  task automatic test_miss_read();
    run_req(1'b0, 16'hBEEF, 10'h3FF);
  endtask

  task automatic test_min_timing();
    t_rcd = 4'd1; t_cl = 4'd1; t_rp = 4'd1;
    run_req(1'b1, 16'h0001, 10'h000);
    run_req(1'b0, 16'h0001, 10'h155);
  endtask

  task automatic test_zero_clamp();
    t_rcd = 4'd0; t_cl = 4'd0; t_rp = 4'd0;
    run_req(1'b0, 16'hFFFF, 10'h001);
  endtask

  task automatic test_max_timing();
    t_rcd = 4'd15; t_cl = 4'd15; t_rp = 4'd15;
    run_req(1'b1, 16'h8000, 10'h200);
    run_req(1'b0, 16'h8000, 10'h100);
  endtask

  initial begin
    test_reset();
    test_closed_read();
    test_hit_write();
    test_miss_read();
    test_min_timing();
    test_zero_clamp();
    test_max_timing();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 50000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule